// File: doc/BRIEF.md
# Constant-Delay Time-Slot Interchange

This block moves 8-bit channels between serial TDM streams. Every input stream is shifted into bytes. Each byte lands in a data memory slot chosen by its stream and channel number. A connection table gives each output stream and channel the input stream and channel it sends. The bit clock is the block clock. A one-cycle frame pulse marks the last bit time of each frame. All streams share one rate, fixed by a parameter: 128 or 256 channels per frame. Bytes travel most significant bit first.

Three data-memory banks rotate on every frame pulse. The frame being received is written into one bank. The outputs read the bank that was filled two frames earlier. Every connection therefore has the same latency: two frames plus the difference between the output and input channel positions. This holds for any mapping, whichever of the two channel numbers is larger. Until three frame pulses have been seen, the outputs send idle ones.

Software writes the connection table through a simple write port. The writes are staged and do not take effect until the next frame boundary, so a frame in progress always uses one consistent map.

Top module: `tsi_switch`

## Requirements
- R1: Each input stream is split into channels of 8 bit times. The first bit of a channel is its most significant bit. A frame has 128 channels when HI_RATE=0 and 256 channels when HI_RATE=1. The output streams use the same channel framing.
- R2: The cycle in which fp_i is high is the last bit time of a frame. In the next cycle the block is at bit 0 of channel 0, whatever position its counters held before.
- R3: A byte received on input stream s, channel m, in frame f is sent in frame f+2 on every output channel n that maps to (s, m). The throughput delay is therefore 2 frames plus (n − m) channel times.
- R4: Any input channel can be sent to any output channel, with n < m or with n > m. This includes the extreme cases of channel 0 fed from the last channel and the last channel fed from channel 0.
- R5: Any input stream can feed any output stream. One input channel can feed several output streams at the same time.
- R6: Before the first frame pulse after reset, and during the two frames that follow it, every output is held at 1 whatever the inputs carry.
- R7: During reset every output is 1. Reset loads the identity map: output stream k, channel n takes input stream k mod N_IN, channel n.
- R8: A connection write (cm_we_i high, with the target given by cm_out_i/cm_ch_i and the source by cm_src_i/cm_src_ch_i) changes nothing in the frame in progress. It applies from the next frame boundary onward. A write in the same cycle as fp_i applies one boundary later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during the last bit time of a frame |
| sin_i | input | N_IN | Serial input streams |
| cm_we_i | input | 1 | Connection table write strobe |
| cm_out_i | input | clog2(N_OUT) | Output stream of the entry being written |
| cm_ch_i | input | clog2(channels) | Output channel of the entry being written |
| cm_src_i | input | clog2(N_IN) | Source input stream for that entry |
| cm_src_ch_i | input | clog2(channels) | Source input channel for that entry |
| sout_o | output | N_OUT | Serial output streams |

## Verification
The bench builds the block with its defaults: four input and four output streams at 128 channels per frame, so each frame is 1024 cycles long. This keeps seven frames, plus a complete rewrite of all 512 connection entries, within a short run. Because there are four streams, the remap can rotate every output onto a different input stream while reversing the channel order. That exercises both signs of n − m and both extreme channels. It also leaves room for a two-output broadcast of one source. The 256-channel rate uses the same counters with one more channel bit, so it is not built separately.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef logic [1:0] bank_t;

  function automatic bank_t bank_inc(bank_t b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/tsi_seq.sv
module tsi_seq
  import tsi_pkg::*;
#(
  parameter int CH_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fp_i,
  output logic [2:0]      bit_o,
  output logic [CH_W-1:0] ch_o,
  output bank_t           wr_bank_o,
  output logic            load_o,
  output logic [CH_W-1:0] ch_nxt_o,
  output bank_t           rd_bank_nxt_o,
  output logic            valid_nxt_o
);
  logic [1:0] frames_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o     <= '0;
      ch_o      <= '0;
      wr_bank_o <= '0;
      frames_q  <= '0;
    end else if (fp_i) begin
      bit_o     <= '0;
      ch_o      <= '0;
      wr_bank_o <= bank_inc(wr_bank_o);
      if (frames_q != 2'd3) frames_q <= frames_q + 2'd1;
    end else begin
      bit_o <= bit_o + 3'd1;
      if (bit_o == 3'd7) ch_o <= ch_o + 1'b1;
    end
  end

  // next cycle begins a channel: prefetch its byte
  always_comb begin
    load_o        = fp_i || (bit_o == 3'd7);
    ch_nxt_o      = fp_i ? '0 : ch_o + 1'b1;
    rd_bank_nxt_o = fp_i ? bank_inc(bank_inc(wr_bank_o)) : bank_inc(wr_bank_o);
    valid_nxt_o   = fp_i ? (frames_q >= 2'd2) : (frames_q == 2'd3);
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int CH    = 128,
  parameter int CH_W  = 7,
  parameter int IS_W  = 2,
  parameter int OS_W  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fp_i,
  input  logic                        we_i,
  input  logic [OS_W-1:0]             wr_out_i,
  input  logic [CH_W-1:0]             wr_ch_i,
  input  logic [IS_W-1:0]             wr_src_i,
  input  logic [CH_W-1:0]             wr_src_ch_i,
  input  logic [CH_W-1:0]             rd_ch_i,
  output logic [N_OUT-1:0][IS_W-1:0]  rd_src_o,
  output logic [N_OUT-1:0][CH_W-1:0]  rd_src_ch_o
);
  typedef struct packed {
    logic [IS_W-1:0] s;
    logic [CH_W-1:0] c;
  } conn_t;

  conn_t act_q [N_OUT][CH];
  conn_t shd_q [N_OUT][CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_OUT; k++)
        for (int n = 0; n < CH; n++) begin
          act_q[k][n] <= conn_t'{s: IS_W'(k % N_IN), c: CH_W'(n)};
          shd_q[k][n] <= conn_t'{s: IS_W'(k % N_IN), c: CH_W'(n)};
        end
    end else begin
      if (we_i && (int'(wr_out_i) < N_OUT))
        shd_q[wr_out_i][wr_ch_i] <= conn_t'{s: wr_src_i, c: wr_src_ch_i};
      if (fp_i) act_q <= shd_q;
    end
  end

  // at a boundary the staged table becomes live for channel 0
  for (genvar k = 0; k < N_OUT; k++) begin : g_rd
    assign rd_src_o[k]    = fp_i ? shd_q[k][0].s : act_q[k][rd_ch_i].s;
    assign rd_src_ch_o[k] = fp_i ? shd_q[k][0].c : act_q[k][rd_ch_i].c;
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int CH    = 128,
  parameter int CH_W  = 7,
  parameter int IS_W  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_IN-1:0]            sin_i,
  input  logic [2:0]                 bit_i,
  input  logic [CH_W-1:0]            ch_i,
  input  bank_t                      wr_bank_i,
  input  bank_t                      rd_bank_i,
  input  logic [N_OUT-1:0][IS_W-1:0] rd_src_i,
  input  logic [N_OUT-1:0][CH_W-1:0] rd_ch_i,
  output logic [N_OUT-1:0][7:0]      rd_data_o
);
  logic [7:0] rd_all [N_IN][N_OUT];

  for (genvar s = 0; s < N_IN; s++) begin : g_in
    logic [7:0] sh_q;
    logic [7:0] mem_q [3][CH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[6:0], sin_i[s]};
    end

    always_ff @(posedge clk_i) begin
      if (bit_i == 3'd7) mem_q[wr_bank_i][ch_i] <= {sh_q[6:0], sin_i[s]};
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_rd
      assign rd_all[s][k] = mem_q[rd_bank_i][rd_ch_i[k]];
    end
  end

  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      rd_data_o[k] = 8'hFF;
      for (int s = 0; s < N_IN; s++)
        if (rd_src_i[k] == IS_W'(s)) rd_data_o[k] = rd_all[s][k];
    end
  end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
  parameter int N_OUT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  valid_i,
  input  logic [N_OUT-1:0][7:0] data_i,
  output logic [N_OUT-1:0]      sout_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [7:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q <= 8'hFF;
      else if (load_i) sh_q <= valid_i ? data_i[k] : 8'hFF;
      else             sh_q <= {sh_q[6:0], 1'b1};
    end

    assign sout_o[k] = sh_q[7];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter bit HI_RATE = 1'b0,
  localparam int CH     = HI_RATE ? 256 : 128,
  localparam int CH_W   = $clog2(CH),
  localparam int IS_W   = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OS_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic [N_IN-1:0]  sin_i,
  input  logic             cm_we_i,
  input  logic [OS_W-1:0]  cm_out_i,
  input  logic [CH_W-1:0]  cm_ch_i,
  input  logic [IS_W-1:0]  cm_src_i,
  input  logic [CH_W-1:0]  cm_src_ch_i,
  output logic [N_OUT-1:0] sout_o
);
  logic [2:0]                 bit_cnt;
  logic [CH_W-1:0]            ch_cnt;
  logic [CH_W-1:0]            ch_nxt;
  bank_t                      wr_bank;
  bank_t                      rd_bank_nxt;
  logic                       load;
  logic                       valid_nxt;
  logic [N_OUT-1:0][IS_W-1:0] src_strm;
  logic [N_OUT-1:0][CH_W-1:0] src_ch;
  logic [N_OUT-1:0][7:0]      rd_byte;

  tsi_seq #(.CH_W(CH_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fp_i         (fp_i),
    .bit_o        (bit_cnt),
    .ch_o         (ch_cnt),
    .wr_bank_o    (wr_bank),
    .load_o       (load),
    .ch_nxt_o     (ch_nxt),
    .rd_bank_nxt_o(rd_bank_nxt),
    .valid_nxt_o  (valid_nxt)
  );

  tsi_conn_mem #(
    .N_IN(N_IN), .N_OUT(N_OUT), .CH(CH), .CH_W(CH_W), .IS_W(IS_W), .OS_W(OS_W)
  ) u_cm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fp_i       (fp_i),
    .we_i       (cm_we_i),
    .wr_out_i   (cm_out_i),
    .wr_ch_i    (cm_ch_i),
    .wr_src_i   (cm_src_i),
    .wr_src_ch_i(cm_src_ch_i),
    .rd_ch_i    (ch_nxt),
    .rd_src_o   (src_strm),
    .rd_src_ch_o(src_ch)
  );

  tsi_data_mem #(
    .N_IN(N_IN), .N_OUT(N_OUT), .CH(CH), .CH_W(CH_W), .IS_W(IS_W)
  ) u_dm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sin_i    (sin_i),
    .bit_i    (bit_cnt),
    .ch_i     (ch_cnt),
    .wr_bank_i(wr_bank),
    .rd_bank_i(rd_bank_nxt),
    .rd_src_i (src_strm),
    .rd_ch_i  (src_ch),
    .rd_data_o(rd_byte)
  );

  tsi_tx #(.N_OUT(N_OUT)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .valid_i(valid_nxt),
    .data_i (rd_byte),
    .sout_o (sout_o)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int N_OUT = 4,
  parameter int CH_W  = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fp_i,
  input logic [N_OUT-1:0] sout_o,
  input logic [2:0]       bit_cnt_i,
  input logic [CH_W-1:0]  ch_cnt_i,
  input logic [1:0]       wr_bank_i
);
  logic [1:0] fp_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         fp_seen_q <= '0;
    else if (fp_i && fp_seen_q != 2'd3) fp_seen_q <= fp_seen_q + 2'd1;
  end

  p_fp_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (bit_cnt_i == 3'd0 && ch_cnt_i == '0));

  p_bit_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> (bit_cnt_i == $past(bit_cnt_i) + 3'd1));

  p_idle_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_seen_q != 2'd3) |-> (&sout_o));

  p_bank_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> $stable(wr_bank_i));

  p_bank_move_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (wr_bank_i != $past(wr_bank_i)));
endmodule

bind tsi_switch tsi_switch_chk #(.N_OUT(N_OUT), .CH_W(CH_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fp_i     (fp_i),
  .sout_o   (sout_o),
  .bit_cnt_i(bit_cnt),
  .ch_cnt_i (ch_cnt),
  .wr_bank_i(wr_bank)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int CLK_P  = 10;
  localparam int N_IN   = 4;
  localparam int N_OUT  = 4;
  localparam int CH     = 128;
  localparam int CH_W   = 7;
  localparam int IS_W   = 2;
  localparam int OS_W   = 2;
  localparam int FBITS  = CH * 8;
  localparam int NF     = 7;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             fp_i;
  logic [N_IN-1:0]  sin_i;
  logic             cm_we_i;
  logic [OS_W-1:0]  cm_out_i;
  logic [CH_W-1:0]  cm_ch_i;
  logic [IS_W-1:0]  cm_src_i;
  logic [CH_W-1:0]  cm_src_ch_i;
  logic [N_OUT-1:0] sout_o;

  tsi_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .HI_RATE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fp_i(fp_i), .sin_i(sin_i),
    .cm_we_i(cm_we_i), .cm_out_i(cm_out_i), .cm_ch_i(cm_ch_i),
    .cm_src_i(cm_src_i), .cm_src_ch_i(cm_src_ch_i), .sout_o(sout_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [7:0] b;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cur_s [N_OUT][CH];
  int   cur_c [N_OUT][CH];
  int   pend_s[N_OUT][CH];
  int   pend_c[N_OUT][CH];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [7:0] in_byte(int fr, int s, int m);
    return 8'(fr * 29 + s * 71 + m * 5 + 3);
  endfunction

  function automatic void check(logic [7:0] act, logic [7:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endfunction

  function automatic bit special(int k, int n);
    return (k <= 1 && n == 5) || (k == 2 && n == 0) || (k == 3 && n == CH - 1);
  endfunction

  // scoreboard producer: expected bytes of one frame, channel-major
  function automatic void push_frame(int f);
    exp_t e;
    for (int n = 0; n < CH; n++)
      for (int k = 0; k < N_OUT; k++) begin
        if (f < 2) begin
          e.b = 8'hFF; e.tag = "R6";
        end else begin
          e.b = in_byte(f - 2, cur_s[k][n], cur_c[k][n]);
          if (f == 2)                        e.tag = "R8";
          else if (f == 3)                   e.tag = "R4";
          else if (f >= 5 && special(k, n))  e.tag = "R5";
          else if (f == 4)                   e.tag = "R3";
          else if (f == 5)                   e.tag = "R2";
          else                               e.tag = "R1";
        end
        q.push_back(e);
      end
  endfunction

  function automatic void cm_wr(int k, int n, int s, int c);
    cm_we_i     = 1'b1;
    cm_out_i    = OS_W'(k);
    cm_ch_i     = CH_W'(n);
    cm_src_i    = IS_W'(s);
    cm_src_ch_i = CH_W'(c);
    pend_s[k][n] = s;
    pend_c[k][n] = c;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // driver
  initial begin
    rst_ni = 1'b0; fp_i = 1'b0; sin_i = '1; cm_we_i = 1'b0;
    cm_out_i = '0; cm_ch_i = '0; cm_src_i = '0; cm_src_ch_i = '0;
    for (int k = 0; k < N_OUT; k++)
      for (int n = 0; n < CH; n++) begin
        cur_s[k][n] = k % N_IN; cur_c[k][n] = n;
        pend_s[k][n] = k % N_IN; pend_c[k][n] = n;
      end
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check({4'h0, sout_o}, 8'h0F, "R7");  // outputs idle high in reset
    rst_ni = 1'b1;
    repeat (4) begin
      @(posedge clk); #(CLK_P/4);
      sin_i = 4'b0101; fp_i = 1'b0;
    end
    @(posedge clk); #(CLK_P/4);
    fp_i = 1'b1;                          // first pulse: frame 0 follows
    push_frame(0);
    for (int fr = 0; fr < NF; fr++) begin
      for (int p = 0; p < FBITS; p++) begin
        @(posedge clk); #(CLK_P/4);
        cm_we_i = 1'b0;
        for (int s = 0; s < N_IN; s++)
          sin_i[s] = in_byte(fr, s, p / 8)[7 - (p % 8)];
        fp_i = (p == FBITS - 1);
        // full remap mid-frame 2: stream rotate, channel reverse (R4, R8)
        if (fr == 2 && p >= 10 && p < 10 + N_OUT * CH)
          cm_wr((p - 10) / CH, (p - 10) % CH, ((p - 10) / CH + 1) % N_IN,
                CH - 1 - (p - 10) % CH);
        // broadcast and extreme channels (R5, R4)
        if (fr == 4 && p == 40) cm_wr(0, 5, 3, 100);
        if (fr == 4 && p == 41) cm_wr(1, 5, 3, 100);
        if (fr == 4 && p == 42) cm_wr(2, 0, 0, CH - 1);
        if (fr == 4 && p == 43) cm_wr(3, CH - 1, 1, 0);
        if (fp_i) begin
          cur_s = pend_s;
          cur_c = pend_c;
          if (fr + 1 < NF) push_frame(fr + 1);
        end
      end
    end
    @(posedge clk); #(CLK_P/4);
    fp_i = 1'b0;
    @(posedge clk); #(CLK_P/4);
    check(8'(q.size()), 8'd0, "R3");     // every expected byte was produced
    done = 1'b1;
    finish_run();
  end

  // monitor: deserializes outputs and consumes the scoreboard
  int         mpos = -1;
  logic [7:0] acc [N_OUT];

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (mpos < 0) begin
        check({4'h0, sout_o}, 8'h0F, "R6");
      end else begin
        for (int k = 0; k < N_OUT; k++) acc[k] = {acc[k][6:0], sout_o[k]};
        if (mpos % 8 == 7) begin
          for (int k = 0; k < N_OUT; k++) begin
            if (q.size() == 0) begin
              check(acc[k], 8'hxx, "R3");
            end else begin
              exp_t e;
              e = q.pop_front();
              check(acc[k], e.b, e.tag);
            end
          end
        end
      end
      if (fp_i)          mpos = 0;
      else if (mpos >= 0) mpos = mpos + 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog act=hung exp=done");
      done = 1'b1;
      finish_run();
    end
  end
endmodule